// File: doc/BRIEF.md
# Sequential Integer Divider with Condition Flags

This block is the division unit of a 32-bit processor datapath. It divides in two forms. The short form divides a full register by a half-width divisor. The wide form divides a double-width dividend, assembled from two registers, by a full-width divisor. Each form can treat its operands as signed or unsigned. The pipeline presents the operand values, the form and signedness, and two destination register indices together on a one-cycle `start` pulse. The block then produces one quotient bit per clock with a restoring shift-and-subtract loop.

When it finishes, the block drives a register write-back port and a set of condition flags (negative, zero, overflow, carry). If the divisor is zero, it instead raises a divide-by-zero request for the surrounding exception logic and changes nothing. In the wide form the block issues two write-backs in consecutive cycles: the remainder first, then the quotient. Because the quotient lands last, it is the value kept when both indices name the same register.

Operand fetch and exception dispatch belong to the surrounding pipeline. The block uses plain `start`/`busy`/`done` control rather than a valid/ready stream. It accepts one operation at a time, applies no back-pressure, and ignores `start` while it is busy.

Top module: `seqdiv_unit`

## Requirements
- R1: After an accepted `start`, `busy` stays high until a `done` pulse of exactly one cycle; in the cycle after `done`, `busy` is low. A `start` raised while `busy` is high is ignored: the running operation's result is unchanged and no extra operation follows.
- R2: A divisor of zero raises `div_zero` together with `done`. No write-back occurs and `flag_valid` stays low. In the short form, only divisor bits 15:0 are tested for zero.
- R3: Whenever `flag_valid` is high, `flag_c` is 0, including on overflow.
- R4: Without overflow, the short form writes one word to `quo_sel` in the `done` cycle. That word holds the 16-bit quotient in bits 15:0 and the 16-bit remainder in bits 31:16. The dividend is `dividend_lo` and the divisor is `divisor[15:0]`.
- R5: The short form overflows when the quotient does not fit in 16 bits. For signed operation the range is -32768..32767; for unsigned operation it is 0..0xFFFF.
- R6: On overflow, `flag_v`=1, `flag_n`=1 and `flag_z`=0, and no register write occurs in either form.
- R7: Without overflow, `flag_v`=0. `flag_n` is the quotient's top bit and `flag_z` is set when the quotient is zero. The quotient is 16 bits in the short form and 32 bits in the wide form.
- R8: The wide form divides the 64-bit value {`dividend_hi`, `dividend_lo`} (high register in bits 63:32) by all of `divisor`. It overflows when the quotient does not fit in 32 bits, using the signed or unsigned range as selected.
- R9: Without overflow, the wide form writes the remainder to `rem_sel` in the cycle before `done`, then the quotient to `quo_sel` in the `done` cycle. If `rem_sel` equals `quo_sel`, that register ends up holding the quotient.
- R10: Signed division truncates the quotient toward zero, and a nonzero remainder takes the sign of the dividend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request carrying operands and mode |
| long_form | input | 1 | 1: 64/32 division, 0: 32/16 division |
| signed_op | input | 1 | 1: two's-complement operands |
| dividend_lo | input | W | Short-form dividend, or bits 31:0 of the wide dividend |
| dividend_hi | input | W | Bits 63:32 of the wide dividend |
| divisor | input | W | Divisor (short form uses bits 15:0) |
| quo_sel | input | IDX_W | Destination register index for the quotient |
| rem_sel | input | IDX_W | Destination register index for the wide-form remainder |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| div_zero | output | 1 | Divide-by-zero request, valid with done |
| wb_en | output | 1 | Register write enable |
| wb_sel | output | IDX_W | Register index being written |
| wb_data | output | W | Value being written |
| flag_valid | output | 1 | Flags below are to be committed |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
The bench builds the block with its defaults: W=32 and IDX_W=3. At W=32 the wide form covers the full 64-bit signed range, so corners such as a most-negative dividend and the exact +/-2^31 and +/-2^15 quotient boundaries can be reached directly. With only eight register indices, random operations often pick the same register for quotient and remainder, which exercises the write ordering and the unchanged-destination rule. The bench keeps its own register file, which it updates only from the write-back port, and compares it after every operation.

// File: rtl/seqdiv_pkg.sv
package seqdiv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_ZERO,
    ST_REMW,
    ST_DONE
  } div_state_e;

  typedef struct packed {
    logic long_form;
    logic signed_op;
  } div_mode_t;

endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
  parameter int W = 32
) (
  input  logic            long_form,
  input  logic            signed_op,
  input  logic [W-1:0]    dividend_lo,
  input  logic [W-1:0]    dividend_hi,
  input  logic [W-1:0]    divisor,
  output logic [2*W-1:0]  num_mag,
  output logic [W-1:0]    den_mag,
  output logic            num_neg,
  output logic            den_neg,
  output logic            den_zero
);
  localparam int DW = 2 * W;
  localparam int HW = W / 2;

  logic [DW-1:0] num_raw;
  logic [W-1:0]  den_raw;

  always_comb begin
    if (long_form) begin
      num_raw = {dividend_hi, dividend_lo};
      den_raw = divisor;
    end else begin
      num_raw = {{W{signed_op & dividend_lo[W-1]}}, dividend_lo};
      den_raw = {{HW{signed_op & divisor[HW-1]}}, divisor[HW-1:0]};
    end
    num_neg  = signed_op & num_raw[DW-1];
    den_neg  = signed_op & den_raw[W-1];
    num_mag  = num_neg ? (~num_raw + 1'b1) : num_raw;
    den_mag  = den_neg ? (~den_raw + 1'b1) : den_raw;
    den_zero = (den_raw == '0);
  end
endmodule

// File: rtl/div_core.sv
module div_core #(
  parameter int W = 32
) (
  input  logic            clk,
  input  logic            load,
  input  logic            step,
  input  logic [2*W-1:0]  num_in,
  input  logic [W-1:0]    den_in,
  output logic [2*W-1:0]  quo,
  output logic [W-1:0]    rem
);
  localparam int DW = 2 * W;

  logic [DW-1:0] acc;
  logic [W-1:0]  part;
  logic [W-1:0]  den;
  logic [W:0]    trial;
  logic [W:0]    diff;
  logic          take;

  always_comb begin
    trial = {part, acc[DW-1]};
    diff  = trial - {1'b0, den};
    take  = (trial >= {1'b0, den});
  end

  always_ff @(posedge clk) begin
    if (load) begin
      acc  <= num_in;
      part <= '0;
      den  <= den_in;
    end else if (step) begin
      acc  <= {acc[DW-2:0], take};
      part <= take ? diff[W-1:0] : trial[W-1:0];
    end
  end

  assign quo = acc;
  assign rem = part;
endmodule

// File: rtl/div_result_pack.sv
module div_result_pack #(
  parameter int W = 32
) (
  input  logic            long_form,
  input  logic            signed_op,
  input  logic            q_neg,
  input  logic            r_neg,
  input  logic [2*W-1:0]  quo_mag,
  input  logic [W-1:0]    rem_mag,
  output logic            ovf,
  output logic [W-1:0]    quo_word,
  output logic [W-1:0]    rem_word,
  output logic            res_n,
  output logic            res_z
);
  localparam int DW = 2 * W;
  localparam int HW = W / 2;
  localparam logic [DW-1:0] LIM_UL = {{W{1'b0}}, {W{1'b1}}};
  localparam logic [DW-1:0] LIM_UW = {{(DW-HW){1'b0}}, {HW{1'b1}}};
  localparam logic [DW-1:0] LIM_SL = {{(W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic [DW-1:0] LIM_SW = {{(DW-HW+1){1'b0}}, {(HW-1){1'b1}}};

  logic [DW-1:0] limit;
  logic [DW-1:0] q_full;
  logic [W-1:0]  r_full;
  logic          q_top;
  logic          q_nil;

  always_comb begin
    unique case ({long_form, signed_op})
      2'b00:   limit = LIM_UW;
      2'b01:   limit = LIM_SW;
      2'b10:   limit = LIM_UL;
      default: limit = LIM_SL;
    endcase
    // a negative quotient may reach one step further than a positive one
    limit  = limit + DW'(signed_op & q_neg);
    ovf    = (quo_mag > limit);
    q_full = q_neg ? (~quo_mag + 1'b1) : quo_mag;
    r_full = r_neg ? (~rem_mag + 1'b1) : rem_mag;
    if (long_form) begin
      quo_word = q_full[W-1:0];
      q_top    = q_full[W-1];
      q_nil    = (q_full[W-1:0] == '0);
    end else begin
      quo_word = {r_full[HW-1:0], q_full[HW-1:0]};
      q_top    = q_full[HW-1];
      q_nil    = (q_full[HW-1:0] == '0);
    end
    rem_word = r_full;
    res_n    = ovf | q_top;
    res_z    = ~ovf & q_nil;
  end
endmodule

// File: rtl/seqdiv_unit.sv
module seqdiv_unit
  import seqdiv_pkg::*;
#(
  parameter int W     = 32,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             long_form,
  input  logic             signed_op,
  input  logic [W-1:0]     dividend_lo,
  input  logic [W-1:0]     dividend_hi,
  input  logic [W-1:0]     divisor,
  input  logic [IDX_W-1:0] quo_sel,
  input  logic [IDX_W-1:0] rem_sel,
  output logic             busy,
  output logic             done,
  output logic             div_zero,
  output logic             wb_en,
  output logic [IDX_W-1:0] wb_sel,
  output logic [W-1:0]     wb_data,
  output logic             flag_valid,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_v,
  output logic             flag_c
);
  localparam int DW    = 2 * W;
  localparam int CNT_W = $clog2(DW + 1);

  div_state_e       state;
  logic [CNT_W-1:0] cnt;
  div_mode_t        mode_q;
  logic             q_neg_q;
  logic             r_neg_q;
  logic [IDX_W-1:0] quo_sel_q;
  logic [IDX_W-1:0] rem_sel_q;

  logic [DW-1:0]    num_mag;
  logic [W-1:0]     den_mag;
  logic             num_neg;
  logic             den_neg;
  logic             den_zero;
  logic [DW-1:0]    core_num;
  logic [DW-1:0]    core_quo;
  logic [W-1:0]     core_rem;
  logic             accept;
  logic             step;

  logic             ovf;
  logic [W-1:0]     quo_word;
  logic [W-1:0]     rem_word;
  logic             res_n;
  logic             res_z;

  div_operand_prep #(.W(W)) u_prep (
    .long_form   (long_form),
    .signed_op   (signed_op),
    .dividend_lo (dividend_lo),
    .dividend_hi (dividend_hi),
    .divisor     (divisor),
    .num_mag     (num_mag),
    .den_mag     (den_mag),
    .num_neg     (num_neg),
    .den_neg     (den_neg),
    .den_zero    (den_zero)
  );

  assign accept   = start && (state == ST_IDLE);
  assign step     = (state == ST_RUN);
  // short form: put the W-bit magnitude at the top so W steps consume it
  assign core_num = long_form ? num_mag : {num_mag[W-1:0], {W{1'b0}}};

  div_core #(.W(W)) u_core (
    .clk    (clk),
    .load   (accept),
    .step   (step),
    .num_in (core_num),
    .den_in (den_mag),
    .quo    (core_quo),
    .rem    (core_rem)
  );

  div_result_pack #(.W(W)) u_pack (
    .long_form (mode_q.long_form),
    .signed_op (mode_q.signed_op),
    .q_neg     (q_neg_q),
    .r_neg     (r_neg_q),
    .quo_mag   (core_quo),
    .rem_mag   (core_rem),
    .ovf       (ovf),
    .quo_word  (quo_word),
    .rem_word  (rem_word),
    .res_n     (res_n),
    .res_z     (res_z)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      mode_q    <= '0;
      q_neg_q   <= 1'b0;
      r_neg_q   <= 1'b0;
      quo_sel_q <= '0;
      rem_sel_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            mode_q    <= '{long_form: long_form, signed_op: signed_op};
            q_neg_q   <= num_neg ^ den_neg;
            r_neg_q   <= num_neg;
            quo_sel_q <= quo_sel;
            rem_sel_q <= rem_sel;
            cnt       <= long_form ? CNT_W'(DW) : CNT_W'(W);
            state     <= den_zero ? ST_ZERO : ST_RUN;
          end
        end
        ST_RUN: begin
          cnt <= cnt - 1'b1;
          if (cnt == CNT_W'(1)) begin
            state <= mode_q.long_form ? ST_REMW : ST_DONE;
          end
        end
        ST_REMW: state <= ST_DONE;
        ST_ZERO: state <= ST_IDLE;
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy       = (state != ST_IDLE);
    done       = (state == ST_DONE) || (state == ST_ZERO);
    div_zero   = (state == ST_ZERO);
    flag_valid = (state == ST_DONE);
    wb_en      = !ovf && ((state == ST_REMW) || (state == ST_DONE));
    wb_sel     = (state == ST_REMW) ? rem_sel_q : quo_sel_q;
    wb_data    = (state == ST_REMW) ? rem_word : quo_word;
    flag_n     = flag_valid & res_n;
    flag_z     = flag_valid & res_z;
    flag_v     = flag_valid & ovf;
    flag_c     = 1'b0;
  end
endmodule

// File: rtl/seqdiv_unit_chk.sv
module seqdiv_unit_chk #(
  parameter int W     = 32,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             div_zero,
  input logic             wb_en,
  input logic [IDX_W-1:0] wb_sel,
  input logic             flag_valid,
  input logic             flag_n,
  input logic             flag_z,
  input logic             flag_v
);
  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R1
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  // R1
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> !busy);

  // R2
  zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_zero |-> (done && !wb_en && !flag_valid));

  // R6
  ovf_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_valid && flag_v) |-> (!wb_en && !$past(wb_en) && flag_n && !flag_z));

  // R9
  rem_then_quo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && !done) |=> (done && wb_en));

  // R9
  wb_in_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> busy);
endmodule

bind seqdiv_unit seqdiv_unit_chk #(.W(W), .IDX_W(IDX_W)) u_seqdiv_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .div_zero   (div_zero),
  .wb_en      (wb_en),
  .wb_sel     (wb_sel),
  .flag_valid (flag_valid),
  .flag_n     (flag_n),
  .flag_z     (flag_z),
  .flag_v     (flag_v)
);

// File: tb/test_seqdiv_unit.sv
module test_seqdiv_unit;
  localparam int W     = 32;
  localparam int IDX_W = 3;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start;
  logic             long_form;
  logic             signed_op;
  logic [W-1:0]     dividend_lo;
  logic [W-1:0]     dividend_hi;
  logic [W-1:0]     divisor;
  logic [IDX_W-1:0] quo_sel;
  logic [IDX_W-1:0] rem_sel;
  logic             busy, done, div_zero, wb_en, flag_valid;
  logic             flag_n, flag_z, flag_v, flag_c;
  logic [IDX_W-1:0] wb_sel;
  logic [W-1:0]     wb_data;

  int checks = 0;
  int errors = 0;

  logic [W-1:0] act_rf [8];
  logic [W-1:0] exp_rf [8];

  always #2 clk = ~clk;

  seqdiv_unit #(.W(W), .IDX_W(IDX_W)) i_seqdiv_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .long_form(long_form),
    .signed_op(signed_op), .dividend_lo(dividend_lo), .dividend_hi(dividend_hi),
    .divisor(divisor), .quo_sel(quo_sel), .rem_sel(rem_sel), .busy(busy),
    .done(done), .div_zero(div_zero), .wb_en(wb_en), .wb_sel(wb_sel),
    .wb_data(wb_data), .flag_valid(flag_valid), .flag_n(flag_n),
    .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
  );

  // bench-side register file, fed only by the write-back port
  always @(negedge clk) if (rst_n && wb_en) act_rf[wb_sel] <= wb_data;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void model(input bit lf, input bit sg,
      input logic [31:0] lo, input logic [31:0] hi, input logic [31:0] dv,
      output bit z, output bit ovf, output logic [31:0] qw,
      output logic [31:0] rw, output bit fn, output bit fz);
    logic [63:0] nd, dd, nm, dm, qm, rm, q, r;
    bit nneg, dneg;
    nd = lf ? {hi, lo} : (sg ? {{32{lo[31]}}, lo} : {32'd0, lo});
    dd = lf ? (sg ? {{32{dv[31]}}, dv} : {32'd0, dv})
            : (sg ? {{48{dv[15]}}, dv[15:0]} : {48'd0, dv[15:0]});
    z = (dd == 0);
    ovf = 0; qw = 0; rw = 0; fn = 0; fz = 0;
    if (z) return;
    nneg = sg && nd[63];
    dneg = sg && dd[63];
    nm = nneg ? -nd : nd;
    dm = dneg ? -dd : dd;
    qm = nm / dm;
    rm = nm % dm;
    q  = (nneg ^ dneg) ? -qm : qm;
    r  = nneg ? -rm : rm;
    if (lf) begin
      ovf = sg ? !(q[63:31] == '0 || q[63:31] == '1) : (q[63:32] != 0);
      qw = q[31:0]; rw = r[31:0]; fn = q[31]; fz = (q[31:0] == 0);
    end else begin
      ovf = sg ? !(q[63:15] == '0 || q[63:15] == '1) : (q[63:16] != 0);
      qw = {r[15:0], q[15:0]}; rw = r[31:0]; fn = q[15]; fz = (q[15:0] == 0);
    end
    if (ovf) begin fn = 1; fz = 0; end
  endfunction

  task automatic do_op(input bit lf, input bit sg, input logic [31:0] lo,
      input logic [31:0] hi, input logic [31:0] dv, input logic [2:0] qs,
      input logic [2:0] rs, input bit poke, input string req);
    bit z, ovf, fn, fz;
    logic [31:0] qw, rw;
    int n, bad, bad_i;
    model(lf, sg, lo, hi, dv, z, ovf, qw, rw, fn, fz);
    if (!z && !ovf) begin
      if (lf) exp_rf[rs] = rw;
      exp_rf[qs] = qw;
    end
    @(negedge clk);
    start = 1; long_form = lf; signed_op = sg; dividend_lo = lo;
    dividend_hi = hi; divisor = dv; quo_sel = qs; rem_sel = rs;
    @(negedge clk);
    start = 0;
    check(busy == 1'b1, "R1", "busy after start", busy, 1);
    if (poke) begin
      start = 1; long_form = ~lf; signed_op = ~sg; dividend_lo = 32'h1234;
      dividend_hi = 0; divisor = 3; quo_sel = qs + 1; rem_sel = rs + 2;
      @(negedge clk);
      start = 0;
    end
    n = 0;
    while (!done && n < 200) begin @(negedge clk); n++; end
    check(done == 1'b1, req, "done seen", done, 1);
    check(div_zero == z, "R2", "div_zero", div_zero, z);
    check(flag_valid == !z, "R2", "flag_valid", flag_valid, !z);
    if (!z) begin
      check(flag_c == 1'b0, "R3", "carry", flag_c, 0);
      check(flag_v == ovf, ovf ? "R6" : "R7", "flag_v", flag_v, ovf);
      check(flag_n == fn, ovf ? "R6" : "R7", "flag_n", flag_n, fn);
      check(flag_z == fz, ovf ? "R6" : "R7", "flag_z", flag_z, fz);
    end
    @(negedge clk);
    check(!done && !busy, "R1", "idle after done", {done, busy}, 0);
    bad = 0; bad_i = 0;
    for (int i = 0; i < 8; i++) if (act_rf[i] !== exp_rf[i]) begin bad++; bad_i = i; end
    check(bad == 0, req, $sformatf("register %0d", bad_i), act_rf[bad_i], exp_rf[bad_i]);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) begin
      act_rf[i] = 32'hA5A50000 | i;
      exp_rf[i] = 32'hA5A50000 | i;
    end
    rst_n = 0; start = 0; long_form = 0; signed_op = 0;
    dividend_lo = 0; dividend_hi = 0; divisor = 0; quo_sel = 0; rem_sel = 0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !wb_en && !flag_valid, "R1", "reset state",
          {busy, done, wb_en, flag_valid}, 0);
    rst_n = 1;

    // R4 packing
    do_op(0, 0, 100, 0, 7, 1, 2, 0, "R4");
    // R5 unsigned boundary: 0xFFFF fits, 0x10000 does not
    do_op(0, 0, 32'h0001FFFE, 0, 2, 2, 0, 0, "R5");
    do_op(0, 0, 32'h00070000, 0, 7, 3, 0, 0, "R5");
    // R5 signed boundary: -32768 fits, +32768 overflows
    do_op(0, 1, 32'hFFFF0000, 0, 2, 4, 0, 0, "R5");
    do_op(0, 1, 32'h00010000, 0, 2, 4, 0, 0, "R5");
    do_op(0, 1, 32'h80000000, 0, 32'hFFFF, 5, 0, 0, "R5");
    // R10 sign handling
    do_op(0, 1, -32'sd7, 0, 2, 5, 0, 0, "R10");
    do_op(0, 1, 32'd7, 0, 32'hFFFE, 6, 0, 0, "R10");
    do_op(1, 1, -32'sd100, 32'hFFFFFFFF, 7, 1, 2, 0, "R10");
    // R7 zero quotient
    do_op(0, 0, 5, 0, 9, 6, 0, 0, "R7");
    // R2 zero divisor, short form ignores upper divisor bits
    do_op(0, 0, 50, 0, 32'h00010000, 1, 0, 0, "R2");
    do_op(1, 1, 50, 3, 0, 1, 2, 0, "R2");
    // R8 wide form boundaries
    do_op(1, 0, 0, 1, 2, 3, 4, 0, "R8");
    do_op(1, 0, 0, 2, 2, 3, 4, 0, "R8");
    do_op(1, 1, 0, 32'hFFFFFFFF, 2, 5, 6, 0, "R8");
    do_op(1, 1, 0, 1, 2, 5, 6, 0, "R8");
    do_op(1, 1, 0, 32'h80000000, 1, 5, 6, 0, "R8");
    // R9 same register keeps the quotient
    do_op(1, 0, 1000, 0, 7, 4, 4, 0, "R9");
    do_op(1, 1, -32'sd1000, 32'hFFFFFFFF, 7, 2, 2, 0, "R9");
    // R1 start while busy has no effect
    do_op(0, 0, 1234, 0, 10, 0, 1, 1, "R1");
    do_op(1, 1, 99, 0, 32'hFFFFFFF7, 6, 7, 1, "R1");

    for (int k = 0; k < 300; k++) begin
      logic [31:0] lo, hi, dv;
      bit lf, sg;
      lf = $urandom_range(0, 1);
      sg = $urandom_range(0, 1);
      lo = $urandom;
      hi = ($urandom_range(0, 2) == 0) ? $urandom : ($urandom_range(0, 1) ? 32'h0 : 32'hFFFFFFFF);
      dv = ($urandom_range(0, 15) == 0) ? 32'h0 : $urandom;
      if (!lf && $urandom_range(0, 1)) lo = lo >> $urandom_range(8, 20);
      do_op(lf, sg, lo, hi, dv, 3'($urandom), 3'($urandom), 0, lf ? "R9" : "R4");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule